// File: doc/BRIEF.md
# Keyboard Data and System Control Port Block

This block sits on the 8-bit I/O bus of a PC/XT-class machine and provides three byte registers. The keyboard data register presents the scancode that is currently held. The keyboard status register shows whether that scancode is still waiting to be read. The system control register is a plain read/write byte: two of its bits drive the tone generator's gate and enable, and one of its bits starts a keyboard self-test.

Scancodes arrive from an upstream converter over a valid/ready handshake. Each code that lands in the holding register raises a one-clock pulse on the keyboard interrupt line. If a code arrives while the holding register is still full, it waits in a one-entry overflow slot. It moves into the holding register, with a fresh interrupt, when software reads the current code.

Software can force the self-test-passed code (0xAA) into the holding register in two ways: a write of any value to the data register, or a rising edge on the self-test bit of the control register.

Top module: `kbd_sysctl_ports`

## Requirements
- R1: After reset, the status register reads 0x00, the data register reads 0x00, the control register reads 0x00, and `irq1`, `spk_gate` and `spk_en` are all low.
- R2: A scancode accepted while the holding register is empty appears on the data register (offset 0). Status bit 0 (offset 4) becomes 1 and status bits 7:1 read 0. `irq1` is high for exactly the one cycle after the accepting edge.
- R3: A read of the data register clears status bit 0. Later reads of the data register return 0x00 until a new code is loaded.
- R4: A scancode accepted while the holding register is full goes to the overflow slot without raising `irq1`, and `sc_ready` drops while the slot is occupied. Reading the data register then moves the waiting code into the holding register and pulses `irq1`.
- R5: A write of any value to the data register loads 0xAA into the holding register, sets status bit 0 and pulses `irq1`.
- R6: A control-register write that changes bit 6 from 0 to 1 loads 0xAA and pulses `irq1`. A write that leaves bit 6 at 1, or that does not set it, loads nothing.
- R7: Reading the control register (offset 1) returns the last value written to it.
- R8: `spk_gate` follows control bit 0 and `spk_en` follows control bit 1.
- R9: A forced 0xAA replaces the code in the holding register but keeps the code waiting in the overflow slot, which is delivered after the 0xAA has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 3 | Register offset: 0 data, 1 control, 4 status |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the register addressed now |
| sc_valid | input | 1 | Incoming scancode valid |
| sc_data | input | 8 | Incoming scancode |
| sc_ready | output | 1 | Block can take a scancode |
| irq1 | output | 1 | Keyboard interrupt pulse |
| spk_gate | output | 1 | Tone generator gate |
| spk_en | output | 1 | Speaker enable |

## Verification
The hardest state to reach is a forced self-test code landing on top of a full holding register while the overflow slot is also occupied. Reaching it needs two scancodes delivered back to back with no read between them, followed by a control write that clears bit 6 and then one that sets it again. The bench builds exactly that sequence. It then reads the data register twice, which shows that the original head code was dropped, that 0xAA arrived, and that the waiting code survived behind it.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int CODE_W   = 8;
  localparam int OFS_DATA = 0;
  localparam int OFS_CTRL = 1;
  localparam int OFS_STAT = 4;
  localparam int ST_BIT   = 6;
  localparam int GATE_BIT = 0;
  localparam int EN_BIT   = 1;
  localparam int OBF_BIT  = 0;
  localparam logic [CODE_W-1:0] SELFTEST_CODE = 8'hAA;

  typedef struct packed {
    logic              v;
    logic [CODE_W-1:0] d;
  } slot_t;

  function automatic logic bit_rises(input logic [CODE_W-1:0] old_v,
                                     input logic [CODE_W-1:0] new_v,
                                     input int unsigned idx);
    return new_v[idx] & ~old_v[idx];
  endfunction

  function automatic logic [CODE_W-1:0] status_byte(input logic obf);
    logic [CODE_W-1:0] s;
    s = '0;
    s[OBF_BIT] = obf;
    return s;
  endfunction
endpackage

// File: rtl/kbd_code_queue.sv
module kbd_code_queue
  import kbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              in_ready,
  input  logic              take,
  input  logic              force_load,
  output logic              head_valid,
  output logic [CODE_W-1:0] head_code,
  output logic              pend_valid,
  output logic              load_evt
);
  slot_t head_q, head_n, pend_q, pend_n;
  logic  accept, to_head;

  assign in_ready = !pend_q.v;
  assign accept   = in_valid && in_ready;

  always_comb begin
    head_n  = head_q;
    pend_n  = pend_q;
    load_evt = 1'b0;
    to_head = 1'b0;
    if (take) head_n.v = 1'b0;
    if (take && pend_q.v) begin
      head_n   = pend_q;
      pend_n.v = 1'b0;
      load_evt = 1'b1;
    end
    if (accept) begin
      if (!head_n.v) begin
        head_n   = '{v: 1'b1, d: in_code};
        to_head  = 1'b1;
        load_evt = 1'b1;
      end else begin
        pend_n = '{v: 1'b1, d: in_code};
      end
    end
    if (force_load) begin
      if (to_head) pend_n = '{v: 1'b1, d: in_code};
      head_n   = '{v: 1'b1, d: SELFTEST_CODE};
      load_evt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      pend_q <= '0;
    end else begin
      head_q <= head_n;
      pend_q <= pend_n;
    end
  end

  assign head_valid = head_q.v;
  assign head_code  = head_q.d;
  assign pend_valid = pend_q.v;
endmodule

// File: rtl/kbd_sysctl_reg.sv
module kbd_sysctl_reg
  import kbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wdata,
  output logic [CODE_W-1:0] ctrl_q,
  output logic              selftest_rise
);
  assign selftest_rise = wr_en && bit_rises(ctrl_q, wdata, ST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata;
  end
endmodule

// File: rtl/kbd_sysctl_ports.sv
module kbd_sysctl_ports
  import kbd_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              sc_valid,
  input  logic [7:0]        sc_data,
  output logic              sc_ready,
  output logic              irq1,
  output logic              spk_gate,
  output logic              spk_en
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic              rd_q;
  logic              data_take, data_wr, ctrl_wr;
  logic              st_rise, force_evt, load_evt;
  logic              head_valid, pend_valid;
  logic [CODE_W-1:0] head_code, ctrl_q;

  assign rd_q      = io_rd && !io_wr;
  assign data_take = rd_q  && (io_addr == A_DATA);
  assign data_wr   = io_wr && (io_addr == A_DATA);
  assign ctrl_wr   = io_wr && (io_addr == A_CTRL);
  assign force_evt = data_wr || st_rise;

  kbd_sysctl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(io_wdata),
    .ctrl_q(ctrl_q), .selftest_rise(st_rise)
  );

  kbd_code_queue u_queue (
    .clk(clk), .rst_n(rst_n), .in_valid(sc_valid), .in_code(sc_data),
    .in_ready(sc_ready), .take(data_take), .force_load(force_evt),
    .head_valid(head_valid), .head_code(head_code),
    .pend_valid(pend_valid), .load_evt(load_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq1 <= 1'b0;
    else        irq1 <= load_evt;
  end

  always_comb begin
    unique case (io_addr)
      A_DATA:  io_rdata = head_valid ? head_code : '0;
      A_CTRL:  io_rdata = ctrl_q;
      A_STAT:  io_rdata = status_byte(head_valid);
      default: io_rdata = '0;
    endcase
  end

  assign spk_gate = ctrl_q[GATE_BIT];
  assign spk_en   = ctrl_q[EN_BIT];
endmodule

// File: rtl/kbd_sysctl_ports_chk.sv
module kbd_sysctl_ports_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] io_addr,
  input logic       io_wr,
  input logic [7:0] io_wdata,
  input logic       sc_ready,
  input logic       irq1,
  input logic       spk_gate,
  input logic       spk_en,
  input logic       head_valid,
  input logic [7:0] head_code,
  input logic       pend_valid,
  input logic       load_evt,
  input logic       force_evt,
  input logic       data_take
);
  // R2: every interrupt pulse coincides with a held code
  p_irq_has_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |-> head_valid);

  // R3: a read with nothing waiting and nothing loading empties the holder
  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_take && !pend_valid && !load_evt) |=> !head_valid);

  // R4: the overflow slot is only used behind a full holder
  p_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_ready |-> head_valid);

  // R5: a forced load leaves the self-test code in the holder
  p_force_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    force_evt |=> (head_valid && head_code == 8'hAA && irq1));

  // R8: speaker outputs take the written control bits
  p_spk_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 3'd1) |=>
      (spk_gate == $past(io_wdata[0]) && spk_en == $past(io_wdata[1])));
endmodule

bind kbd_sysctl_ports kbd_sysctl_ports_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
  .io_wdata(io_wdata), .sc_ready(sc_ready), .irq1(irq1),
  .spk_gate(spk_gate), .spk_en(spk_en), .head_valid(head_valid),
  .head_code(head_code), .pend_valid(pend_valid), .load_evt(load_evt),
  .force_evt(force_evt), .data_take(data_take)
);

// File: tb/kbd_sysctl_ports_test.sv
module kbd_sysctl_ports_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] io_addr = 0;
  logic       io_rd = 0, io_wr = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata;
  logic       sc_valid = 0;
  logic [7:0] sc_data = 0;
  logic       sc_ready, irq1, spk_gate, spk_en;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_sysctl_ports uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .sc_valid(sc_valid), .sc_data(sc_data), .sc_ready(sc_ready),
    .irq1(irq1), .spk_gate(spk_gate), .spk_en(spk_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1; #1 d = io_rdata;
    @(negedge clk); io_rd = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    io_addr = a; #1 d = io_rdata;
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk); sc_data = c; sc_valid = 1;
    @(negedge clk); sc_valid = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    peek(3'd4, v); chk("R1 status", v, 0);
    peek(3'd0, v); chk("R1 data", v, 0);
    peek(3'd1, v); chk("R1 ctrl", v, 0);
    chk("R1 irq1", irq1, 0);
    chk("R1 spk", {spk_en, spk_gate}, 0);
  endtask

  task automatic t_deliver;
    logic [7:0] v;
    send(8'h1E);
    chk("R2 irq pulse", irq1, 1);
    peek(3'd4, v); chk("R2 status", v, 8'h01);
    @(negedge clk); chk("R2 irq one cycle", irq1, 0);
    rd(3'd0, v); chk("R2 data", v, 8'h1E);
    peek(3'd4, v); chk("R3 obf cleared", v, 0);
    rd(3'd0, v); chk("R3 empty read", v, 0);
  endtask

  task automatic t_pending;
    logic [7:0] v;
    send(8'h10);
    @(negedge clk);
    send(8'h20);
    chk("R4 no irq on pend", irq1, 0);
    chk("R4 ready low", sc_ready, 0);
    rd(3'd0, v); chk("R4 first", v, 8'h10);
    chk("R4 promote irq", irq1, 1);
    chk("R4 ready back", sc_ready, 1);
    rd(3'd0, v); chk("R4 second", v, 8'h20);
    peek(3'd4, v); chk("R4 empty", v, 0);
  endtask

  task automatic t_data_write;
    logic [7:0] v;
    wr(3'd0, 8'h55);
    chk("R5 irq", irq1, 1);
    peek(3'd4, v); chk("R5 status", v, 8'h01);
    rd(3'd0, v); chk("R5 code", v, 8'hAA);
  endtask

  task automatic t_ctrl;
    logic [7:0] v;
    wr(3'd1, 8'h03);
    chk("R8 gate", spk_gate, 1); chk("R8 en", spk_en, 1);
    chk("R6 no edge", irq1, 0);
    peek(3'd1, v); chk("R7 readback", v, 8'h03);
    wr(3'd1, 8'h02);
    chk("R8 gate off", spk_gate, 0); chk("R8 en kept", spk_en, 1);
    wr(3'd1, 8'h40);
    chk("R6 rise irq", irq1, 1);
    rd(3'd0, v); chk("R6 code", v, 8'hAA);
    wr(3'd1, 8'h41);
    chk("R6 held no irq", irq1, 0);
    peek(3'd4, v); chk("R6 held no load", v, 0);
    peek(3'd1, v); chk("R7 readback2", v, 8'h41);
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h40);
    chk("R6 second rise", irq1, 1);
    rd(3'd0, v); chk("R6 code2", v, 8'hAA);
  endtask

  task automatic t_force_pending;
    logic [7:0] v;
    send(8'h30);
    send(8'h31);
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h40);
    rd(3'd0, v); chk("R9 forced", v, 8'hAA);
    rd(3'd0, v); chk("R9 kept pend", v, 8'h31);
    peek(3'd4, v); chk("R9 empty", v, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_deliver();
    t_pending();
    t_data_write();
    t_ctrl();
    t_force_pending();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule